// File: doc/BRIEF.md
# Package Low-Power Sequencer

This block tracks the power state of a processor package. Four active-low sideband lines from the platform request stop-clock, sleep, deep sleep and deeper sleep. The block walks the package through a ladder of six states: run, stop grant, stop grant with a snoop in service, sleep, deep sleep and deeper sleep. Each rung moves up or down by exactly one step per clock. A line that asks for a rung further down the ladder has no effect until the rung above it has been reached.

Snoops get special handling. In stop grant, a snoop request moves the package into a snoop service state until the snoop completes. In deeper sleep, the core cannot snoop, so a snoop request instead raises a wake indication. Leaving stop grant for run waits until the memory side reports that its DLLs are awake and self-refresh has ended. Only the first stop-grant entry from run is acknowledged. Returns to stop grant from sleep or from snoop service are not treated as new grants.

Top module: `pkg_lp_seq`

## Requirements
- R1: Reset (rst_ni low) puts the state at run (state_o code 0). After reset, snoop_ok_o is 1 and grant_ack_o, mem_wake_o and snoop_wake_o are 0.
- R2: The four sideband lines are active low and pass through SYNC_STAGES flops (default 2) before use. With the defaults, a line change is acted on at the third rising edge after it.
- R3: With stop_clk_ni asserted in run, the state moves to stop grant (code 1). grant_ack_o is high for exactly that one cycle.
- R4: A snoop_req_i sampled in stop grant moves the state to snoop service (code 2) at the next edge. This has priority over the other stop-grant moves. The state stays there until snoop_done_i is sampled high, then returns to stop grant.
- R5: Sleep moves stop grant to sleep (code 3) and back. Deep sleep moves sleep to deep sleep (code 4) and back. Deeper sleep moves deep sleep to deeper sleep (code 5) and back.
- R6: The state changes by at most one rung per clock. Several lines changing together are taken one rung per cycle. A line whose rung is not adjacent, such as sleep while in run, has no effect.
- R7: In deeper sleep, snoop_ok_o is 0. A snoop_req_i there raises snoop_wake_o in the same cycle and leaves the state unchanged. In every other state, snoop_ok_o is 1.
- R8: grant_ack_o pulses only on entry to stop grant from run. Re-entry to stop grant from sleep or from snoop service produces no pulse.
- R9: When stop-clock is released in stop grant, mem_wake_o stays high while mem_ready_i is low. The state moves to run at the first edge where mem_ready_i is sampled high.
- R10: snoop_req_i has no effect on the state in run or in the sleep rungs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_clk_ni | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_ni | input | 1 | Sleep request, active low, asynchronous |
| deep_sleep_ni | input | 1 | Deep-sleep request, active low, asynchronous |
| deeper_sleep_ni | input | 1 | Deeper-sleep request, active low, asynchronous |
| snoop_req_i | input | 1 | Snoop request, synchronous |
| snoop_done_i | input | 1 | Snoop serviced, synchronous |
| mem_ready_i | input | 1 | DLLs awake and memory out of self-refresh |
| state_o | output | 3 | Current state code (0 run … 5 deeper sleep) |
| snoop_ok_o | output | 1 | Core can accept snoops |
| mem_wake_o | output | 1 | Memory must be woken before leaving stop grant |
| snoop_wake_o | output | 1 | Snoop arrived in deeper sleep; wake required |
| grant_ack_o | output | 1 | One-cycle accept of a stop-grant request |

## Verification
The bench uses the default two-stage synchronizer, so each line change is acted on after a fixed three-edge latency. This lets every rung of a multi-line release be sampled in its own cycle. It drops all three sleep lines at once and releases them at once, which exposes any skipped rung. It also holds mem_ready_i low across a stop-clock release to show the exit wait, and it counts grant pulses over returns from sleep and from snoop service.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int unsigned STATE_W = 3;
  typedef enum logic [STATE_W-1:0] {
    LP_RUN       = 3'd0,
    LP_GRANT     = 3'd1,
    LP_GRANT_SNP = 3'd2,
    LP_SLEEP     = 3'd3,
    LP_DEEP      = 3'd4,
    LP_DEEPER    = 3'd5
  } lp_state_e;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stop_i,
  input  logic      sleep_i,
  input  logic      deep_i,
  input  logic      deeper_i,
  input  logic      snoop_req_i,
  input  logic      snoop_done_i,
  input  logic      mem_ready_i,
  output lp_state_e state_o,
  output logic      enter_grant_o
);
  lp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LP_RUN:       if (stop_i) state_d = LP_GRANT;
      LP_GRANT: begin
        if (snoop_req_i)        state_d = LP_GRANT_SNP;
        else if (!stop_i)       state_d = mem_ready_i ? LP_RUN : LP_GRANT;
        else if (sleep_i)       state_d = LP_SLEEP;
      end
      LP_GRANT_SNP: if (snoop_done_i) state_d = LP_GRANT;
      LP_SLEEP: begin
        if (!sleep_i)           state_d = LP_GRANT;
        else if (deep_i)        state_d = LP_DEEP;
      end
      LP_DEEP: begin
        if (!deep_i)            state_d = LP_SLEEP;
        else if (deeper_i)      state_d = LP_DEEPER;
      end
      LP_DEEPER:    if (!deeper_i) state_d = LP_DEEP;
      default:      state_d = LP_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LP_RUN;
    else         state_q <= state_d;
  end

  assign state_o       = state_q;
  assign enter_grant_o = (state_q == LP_RUN) && (state_d == LP_GRANT);

  function automatic logic adj(lp_state_e a, lp_state_e b);
    unique case (a)
      LP_RUN:       adj = b inside {LP_RUN, LP_GRANT};
      LP_GRANT:     adj = b inside {LP_GRANT, LP_RUN, LP_GRANT_SNP, LP_SLEEP};
      LP_GRANT_SNP: adj = b inside {LP_GRANT_SNP, LP_GRANT};
      LP_SLEEP:     adj = b inside {LP_SLEEP, LP_GRANT, LP_DEEP};
      LP_DEEP:      adj = b inside {LP_DEEP, LP_SLEEP, LP_DEEPER};
      LP_DEEPER:    adj = b inside {LP_DEEPER, LP_DEEP};
      default:      adj = 1'b0;
    endcase
  endfunction

  p_adjacent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj($past(state_q), state_q));

  p_snoop_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_GRANT_SNP && $past(state_q) != LP_GRANT_SNP)
      |-> $past(state_q) == LP_GRANT && $past(snoop_req_i));

  p_exit_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_RUN && $past(state_q) == LP_GRANT) |-> $past(mem_ready_i));

  p_deeper_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == LP_DEEPER && $past(deeper_i)) |-> state_q == LP_DEEPER);
endmodule

// File: rtl/lp_out.sv
module lp_out
  import lp_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  lp_state_e state_i,
  input  logic      stop_i,
  input  logic      snoop_req_i,
  input  logic      enter_grant_i,
  output logic      snoop_ok_o,
  output logic      mem_wake_o,
  output logic      snoop_wake_o,
  output logic      grant_ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= enter_grant_i;
  end

  assign snoop_ok_o   = (state_i != LP_DEEPER);
  assign snoop_wake_o = (state_i == LP_DEEPER) && snoop_req_i;
  assign mem_wake_o   = (state_i == LP_GRANT) && !stop_i;
  assign grant_ack_o  = ack_q;

  p_ack_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ack_o |=> !grant_ack_o);

  p_ack_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ack_o |-> (state_i == LP_GRANT && $past(state_i) == LP_RUN));
endmodule

// File: rtl/pkg_lp_seq.sv
module pkg_lp_seq
  import lp_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_clk_ni,
  input  logic               sleep_ni,
  input  logic               deep_sleep_ni,
  input  logic               deeper_sleep_ni,
  input  logic               snoop_req_i,
  input  logic               snoop_done_i,
  input  logic               mem_ready_i,
  output logic [STATE_W-1:0] state_o,
  output logic               snoop_ok_o,
  output logic               mem_wake_o,
  output logic               snoop_wake_o,
  output logic               grant_ack_o
);
  localparam int unsigned NUM_LINES = 4;

  logic [NUM_LINES-1:0] raw_n, sync_n, req;
  lp_state_e state;
  logic      enter_grant;

  assign raw_n = {deeper_sleep_ni, deep_sleep_ni, sleep_ni, stop_clk_ni};

  lp_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_n),
    .q_o    (sync_n)
  );

  assign req = ~sync_n;

  lp_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stop_i        (req[0]),
    .sleep_i       (req[1]),
    .deep_i        (req[2]),
    .deeper_i      (req[3]),
    .snoop_req_i   (snoop_req_i),
    .snoop_done_i  (snoop_done_i),
    .mem_ready_i   (mem_ready_i),
    .state_o       (state),
    .enter_grant_o (enter_grant)
  );

  lp_out u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .stop_i        (req[0]),
    .snoop_req_i   (snoop_req_i),
    .enter_grant_i (enter_grant),
    .snoop_ok_o    (snoop_ok_o),
    .mem_wake_o    (mem_wake_o),
    .snoop_wake_o  (snoop_wake_o),
    .grant_ack_o   (grant_ack_o)
  );

  assign state_o = state;
endmodule

// File: tb/pkg_lp_seq_bench.sv
`timescale 1ns/1ps
module pkg_lp_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_n = 1'b1, sleep_n = 1'b1, deep_n = 1'b1, deeper_n = 1'b1;
  logic snp_req = 1'b0, snp_done = 1'b0, mem_rdy = 1'b0;
  logic [2:0] state;
  logic snoop_ok, mem_wake, snoop_wake, grant_ack;

  int checks = 0, failures = 0, ack_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkg_lp_seq u_pkg_lp_seq (
    .clk_i (clk), .rst_ni (rst_n),
    .stop_clk_ni (stop_n), .sleep_ni (sleep_n),
    .deep_sleep_ni (deep_n), .deeper_sleep_ni (deeper_n),
    .snoop_req_i (snp_req), .snoop_done_i (snp_done), .mem_ready_i (mem_rdy),
    .state_o (state), .snoop_ok_o (snoop_ok), .mem_wake_o (mem_wake),
    .snoop_wake_o (snoop_wake), .grant_ack_o (grant_ack)
  );

  always @(negedge clk) if (rst_n && grant_ack) ack_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 state", state, 0);
    chk("R1 snoop_ok", snoop_ok, 1);
    chk("R1 outputs", {grant_ack, mem_wake, snoop_wake}, 0);
  endtask

  task automatic t_grant;
    stop_n = 1'b0;
    step(2);
    chk("R2 latency hold", state, 0);
    step(1);
    chk("R3 grant", state, 1);
    chk("R3 ack", grant_ack, 1);
    step(1);
    chk("R3 ack pulse", ack_cnt, 1);
  endtask

  task automatic t_snoop;
    snp_req = 1'b1; step(1); snp_req = 1'b0;
    chk("R4 snoop entry", state, 2);
    step(3);
    chk("R4 hold until done", state, 2);
    snp_done = 1'b1; step(1); snp_done = 1'b0;
    chk("R4 back to grant", state, 1);
    chk("R8 no ack after snoop", ack_cnt, 1);
  endtask

  task automatic t_ladder_up;
    sleep_n = 1'b0; deep_n = 1'b0; deeper_n = 1'b0;
    step(3); chk("R6 rung sleep", state, 3);
    step(1); chk("R6 rung deep", state, 4);
    step(1); chk("R5 rung deeper", state, 5);
  endtask

  task automatic t_deeper_snoop;
    chk("R7 snoop_ok low", snoop_ok, 0);
    snp_req = 1'b1; #1;
    chk("R7 wake", snoop_wake, 1);
    step(2);
    chk("R7 state held", state, 5);
    snp_req = 1'b0; #1;
    chk("R7 wake clears", snoop_wake, 0);
  endtask

  task automatic t_ladder_down;
    sleep_n = 1'b1; deep_n = 1'b1; deeper_n = 1'b1;
    step(3); chk("R5 down deep", state, 4);
    chk("R7 snoop_ok high", snoop_ok, 1);
    step(1); chk("R6 down sleep", state, 3);
    snp_req = 1'b1; step(1); snp_req = 1'b0;
    chk("R5 down grant", state, 1);
    chk("R8 no ack after sleep", ack_cnt, 1);
  endtask

  task automatic t_sleep_snoop;
    sleep_n = 1'b0; step(4);
    chk("R5 sleep", state, 3);
    snp_req = 1'b1; step(2); snp_req = 1'b0;
    chk("R10 snoop in sleep", state, 3);
    sleep_n = 1'b1; step(4);
    chk("R5 back grant", state, 1);
  endtask

  task automatic t_exit;
    stop_n = 1'b1; step(4);
    chk("R9 wait state", state, 1);
    chk("R9 mem_wake", mem_wake, 1);
    step(3);
    chk("R9 still waiting", state, 1);
    mem_rdy = 1'b1; step(1);
    chk("R9 run", state, 0);
    chk("R9 mem_wake off", mem_wake, 0);
    mem_rdy = 1'b0;
  endtask

  task automatic t_run_ignored;
    sleep_n = 1'b0; snp_req = 1'b1; step(5); snp_req = 1'b0;
    chk("R6 sleep in run", state, 0);
    chk("R10 snoop in run", state, 0);
    sleep_n = 1'b1; step(3);
  endtask

  task automatic t_reset_mid;
    stop_n = 1'b0; step(4);
    chk("R3 second grant", ack_cnt, 2);
    rst_n = 1'b0; step(1);
    chk("R1 mid reset", state, 0);
    stop_n = 1'b1; step(1); rst_n = 1'b1; step(3);
    chk("R1 after release", state, 0);
  endtask

  initial begin
    step(3);
    t_reset;
    rst_n = 1'b1;
    step(2);
    t_grant;
    t_snoop;
    t_ladder_up;
    t_deeper_snoop;
    t_ladder_down;
    t_sleep_snoop;
    t_exit;
    t_run_ignored;
    t_reset_mid;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule